// File: doc/BRIEF.md
# Serial Code Lock

A Moore state machine that acts as an electronic key. A key is typed in one bit at a time on a serial input, qualified by a valid strobe, and each bit is compared with a secret code fixed at elaboration. Every matching bit moves the machine one step along the entry sequence. After the last matching bit, it opens for a single cycle and then falls back to the rest state.

Any wrong bit sends the machine straight into an error state, which always passes back through rest. Entry never resynchronises on a partial match: after an error the whole code must be entered again from its first bit. Both flags decode the current state only.

The secret code is derived from decimal digits held in a parameter. A digit below a threshold of five contributes a 1, and any other digit contributes a 0.

Top module: `serial_code_lock`

## Requirements
- R1: Code bit k (k = 0 is the first bit entered) is 1 when digit k is below 5 and 0 otherwise. The digits are packed as 4-bit BCD in `DIGITS`, with digit 0 in the most significant nibble. The default 16'h0864 gives entry order 1,0,0,1, and 16'h2345 gives 1,1,1,0.
- R2: While `rst_ni` is low, the machine is held in rest with `unlock_o` and `error_o` both low. This reset acts asynchronously.
- R3: A key bit is taken only on a rising clock edge where `bit_valid_i` is high. With `bit_valid_i` low, in rest or mid-entry, the state holds.
- R4: A key bit equal to the expected code bit advances the entry. The edge that takes the last matching bit raises `unlock_o`.
- R5: A key bit that differs from the expected code bit, at any position, raises `error_o` from the next edge.
- R6: The error state lasts exactly one cycle and then goes to rest whatever the inputs are. A bit presented during that cycle is discarded.
- R7: `unlock_o` is high for exactly one cycle, after which the machine is in rest whatever the inputs are. A bit presented during that cycle is discarded.
- R8: `unlock_o` and `error_o` are both low in rest and in every partial-entry state.
- R9: After an error, entry restarts at code bit 0. A trailing partial match is never reused.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Serial key bit |
| bit_valid_i | input | 1 | Qualifies bit_i on the current edge |
| unlock_o | output | 1 | High in the single open cycle |
| error_o | output | 1 | High in the single error cycle |

## Verification
The bench targets a mismatch on the very last code bit, because a design with an off-by-one position compare would open there instead of flagging an error. It sends bits during the open and error cycles, which catches a design that consumes them and then shortens the next entry. It removes the valid strobe in the middle of an entry, which exposes a design that advances on unqualified bits. It retries straight after an error, where a design that resynchronises on a partial match would open too early. A second instance with different digits checks the threshold rule, so a design that inverted the rule, or read the digits in the wrong order, would reject the correct key.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    MODE_REST = 2'd0,
    MODE_PROG = 2'd1,
    MODE_OPEN = 2'd2,
    MODE_ERR  = 2'd3
  } lock_mode_e;

  function automatic logic digit_to_bit(input logic [3:0] digit, input int unsigned thresh);
    return (int'(digit) < int'(thresh));
  endfunction
endpackage

// File: rtl/lock_code_gen.sv
module lock_code_gen #(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned DIGIT_W    = 4,
  parameter int unsigned THRESH     = 5,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] DIGITS = 16'h0864
) (
  output logic [NUM_DIGITS-1:0] code_o
);
  // code_o[k] is the k-th bit entered; digit 0 sits in the top nibble
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_bit
    localparam int unsigned LSB = (NUM_DIGITS - 1 - k) * DIGIT_W;
    assign code_o[k] = lock_pkg::digit_to_bit(DIGITS[LSB +: DIGIT_W], THRESH);
  end
endmodule

// File: rtl/lock_step_ctrl.sv
module lock_step_ctrl
  import lock_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  localparam int unsigned IDX_W = $clog2(NUM_DIGITS + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_DIGITS-1:0] code_i,
  input  logic                  bit_i,
  input  logic                  bit_valid_i,
  output lock_mode_e            mode_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DIGITS - 1);

  lock_mode_e       mode_q, mode_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             legal;
  logic             match;

  // rest holds idx 0; partial entry holds idx 1..LAST
  always_comb begin
    unique case (mode_q)
      MODE_REST: legal = (idx_q == '0);
      MODE_PROG: legal = (idx_q != '0) && (idx_q <= LAST);
      default:   legal = 1'b1;
    endcase
  end

  assign match = legal && (bit_i == code_i[idx_q]);

  always_comb begin
    mode_d = mode_q;
    idx_d  = idx_q;
    if (!legal) begin
      mode_d = MODE_REST;
      idx_d  = '0;
    end else begin
      unique case (mode_q)
        MODE_REST, MODE_PROG: begin
          if (bit_valid_i) begin
            if (!match) begin
              mode_d = MODE_ERR;
              idx_d  = '0;
            end else if (idx_q == LAST) begin
              mode_d = MODE_OPEN;
              idx_d  = '0;
            end else begin
              mode_d = MODE_PROG;
              idx_d  = idx_q + 1'b1;
            end
          end
        end
        default: begin
          mode_d = MODE_REST;
          idx_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_REST;
      idx_q  <= '0;
    end else begin
      mode_q <= mode_d;
      idx_q  <= idx_d;
    end
  end

  assign mode_o = mode_q;

  // R3
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_valid_i && legal && (mode_q == MODE_REST || mode_q == MODE_PROG))
      |=> ($stable(mode_q) && $stable(idx_q)));

  // R5
  mismatch_to_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && legal && (mode_q == MODE_REST || mode_q == MODE_PROG) && !match)
      |=> (mode_q == MODE_ERR));

  // R4
  advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_i && match && (mode_q == MODE_REST || mode_q == MODE_PROG) && idx_q != LAST)
      |=> (mode_q == MODE_PROG && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/lock_flag_dec.sv
module lock_flag_dec
  import lock_pkg::*;
(
  input  lock_mode_e mode_i,
  output logic       unlock_o,
  output logic       error_o
);
  always_comb begin
    unlock_o = 1'b0;
    error_o  = 1'b0;
    unique case (mode_i)
      MODE_OPEN: unlock_o = 1'b1;
      MODE_ERR:  error_o  = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/serial_code_lock.sv
module serial_code_lock
  import lock_pkg::*;
#(
  parameter int unsigned NUM_DIGITS = 4,
  parameter int unsigned DIGIT_W    = 4,
  parameter int unsigned THRESH     = 5,
  parameter logic [NUM_DIGITS*DIGIT_W-1:0] DIGITS = 16'h0864
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  input  logic bit_valid_i,
  output logic unlock_o,
  output logic error_o
);
  logic [NUM_DIGITS-1:0] code;
  lock_mode_e            mode;

  lock_code_gen #(
    .NUM_DIGITS(NUM_DIGITS),
    .DIGIT_W   (DIGIT_W),
    .THRESH    (THRESH),
    .DIGITS    (DIGITS)
  ) u_code (
    .code_o(code)
  );

  lock_step_ctrl #(
    .NUM_DIGITS(NUM_DIGITS)
  ) u_step (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .code_i     (code),
    .bit_i      (bit_i),
    .bit_valid_i(bit_valid_i),
    .mode_o     (mode)
  );

  lock_flag_dec u_dec (
    .mode_i  (mode),
    .unlock_o(unlock_o),
    .error_o (error_o)
  );

  // R7
  unlock_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |=> (!unlock_o && !error_o));

  // R6
  err_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> (!error_o && !unlock_o));

  // R4
  open_needs_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(unlock_o) |-> $past(bit_valid_i));
endmodule

// File: tb/serial_code_lock_test.sv
module serial_code_lock_test;
  localparam logic [15:0] DIG_A = 16'h0864;
  localparam logic [15:0] DIG_B = 16'h2345;
  localparam int N = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_bit = 1'b0, a_vld = 1'b0, b_bit = 1'b0, b_vld = 1'b0;
  logic a_unl, a_err, b_unl, b_err;

  int checks = 0;
  int fails  = 0;
  // model: 0 = rest/partial, 2 = open, 3 = error
  int m_mode = 0;
  int m_cnt  = 0;

  always #2 clk = ~clk;

  serial_code_lock #(.DIGITS(DIG_A)) uut (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(a_bit), .bit_valid_i(a_vld),
    .unlock_o(a_unl), .error_o(a_err));

  serial_code_lock #(.DIGITS(DIG_B)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .bit_i(b_bit), .bit_valid_i(b_vld),
    .unlock_o(b_unl), .error_o(b_err));

  function automatic logic code_bit(input logic [15:0] d, input int k);
    return (d[(3-k)*4 +: 4] < 4'd5);
  endfunction

  task automatic check(input string tag, input logic act_u, input logic act_e,
                       input logic exp_u, input logic exp_e);
    checks++;
    if (act_u !== exp_u || act_e !== exp_e) begin
      fails++;
      $display("FAIL %s: unlock/error actual %b%b expected %b%b", tag, act_u, act_e, exp_u, exp_e);
    end
  endtask

  task automatic model_step(input logic b, input logic v);
    if (m_mode != 0) begin
      m_mode = 0; m_cnt = 0;
    end else if (v) begin
      if (b == code_bit(DIG_A, m_cnt)) begin
        if (m_cnt == N-1) begin m_mode = 2; m_cnt = 0; end
        else m_cnt++;
      end else begin
        m_mode = 3; m_cnt = 0;
      end
    end
  endtask

  // drive at negedge, update model at posedge, compare at next negedge
  task automatic cyc(input logic b, input logic v, input string tag);
    a_bit = b; a_vld = v;
    @(posedge clk);
    model_step(b, v);
    @(negedge clk);
    check(tag, a_unl, a_err, m_mode == 2, m_mode == 3);
  endtask

  task automatic enter_code(input string tag);
    for (int k = 0; k < N; k++) cyc(code_bit(DIG_A, k), 1'b1, tag);
  endtask

  task automatic cyc_b(input logic b, input logic exp_u, input logic exp_e, input string tag);
    b_bit = b; b_vld = 1'b1;
    @(posedge clk);
    @(negedge clk);
    b_vld = 1'b0;
    check(tag, b_unl, b_err, exp_u, exp_e);
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    check("R2 reset", a_unl, a_err, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 after release", a_unl, a_err, 1'b0, 1'b0);

    // R4 R8: full code, partial states quiet
    enter_code("R4 R8 entry");
    cyc(1'b0, 1'b0, "R7 back to rest");

    // R3: gaps in valid, including a wrong bit value while invalid
    cyc(code_bit(DIG_A, 0), 1'b1, "R3 first");
    cyc(~code_bit(DIG_A, 1), 1'b0, "R3 ignored bit");
    cyc(~code_bit(DIG_A, 1), 1'b0, "R3 ignored bit");
    for (int k = 1; k < N; k++) cyc(code_bit(DIG_A, k), 1'b1, "R3 R4 resume");

    // R7: bit offered during open cycle is dropped
    cyc(code_bit(DIG_A, 0), 1'b1, "R7 bit in open");
    enter_code("R7 full entry after");
    cyc(1'b0, 1'b0, "R7 idle");

    // R5: mismatch on the last bit
    for (int k = 0; k < N-1; k++) cyc(code_bit(DIG_A, k), 1'b1, "R5 prefix");
    cyc(~code_bit(DIG_A, N-1), 1'b1, "R5 last bit wrong");
    // R6: bit during error dropped
    cyc(code_bit(DIG_A, 0), 1'b1, "R6 bit in error");
    // R9: restart from bit 0
    enter_code("R9 retry");
    cyc(1'b0, 1'b0, "R9 idle");

    // R5: mismatch at first position
    cyc(~code_bit(DIG_A, 0), 1'b1, "R5 first bit wrong");
    cyc(1'b0, 1'b0, "R6 return");

    // R2: async reset mid entry
    cyc(code_bit(DIG_A, 0), 1'b1, "R2 prefix");
    cyc(code_bit(DIG_A, 1), 1'b1, "R2 prefix");
    #1 rst_n = 1'b0;
    #1 check("R2 async", a_unl, a_err, 1'b0, 1'b0);
    m_mode = 0; m_cnt = 0;
    @(negedge clk);
    rst_n = 1'b1;
    cyc(code_bit(DIG_A, 2), 1'b1, "R2 R9 no resume");
    cyc(1'b0, 1'b0, "R6 return");

    // R1: second digit set 2,3,4,5 -> 1,1,1,0
    cyc_b(1'b1, 1'b0, 1'b0, "R1 b0");
    cyc_b(1'b1, 1'b0, 1'b0, "R1 b1");
    cyc_b(1'b1, 1'b0, 1'b0, "R1 b2");
    cyc_b(1'b0, 1'b1, 1'b0, "R1 open");
    @(negedge clk);
    cyc_b(1'b1, 1'b0, 1'b0, "R1 b0");
    cyc_b(1'b0, 1'b0, 1'b1, "R1 wrong");
    @(negedge clk);

    // random mix, biased toward correct bits
    for (int i = 0; i < 4000; i++) begin
      logic v, b;
      v = ($urandom % 4) != 0;
      b = (($urandom % 8) != 0) ? code_bit(DIG_A, m_cnt) : ($urandom % 2 == 1);
      cyc(b, v, "R3 R4 R5 R6 R7 random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule